// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is one channel of a DMA engine. Software programs a source start address, a destination start address, a transfer count, an interrupt threshold and a control word through a small register port. When it sets the enable bit, the channel moves data one transfer at a time. Each transfer is one read beat on a simple memory-side bus followed by one write beat carrying the same data. The width of each transfer is 1, 2 or 4 bytes.

Each side can keep its address fixed or step it by the transfer width. A channel in software mode runs as soon as it is enabled. A channel in hardware mode moves a burst of 1, 4 or 8 transfers for each level or edge seen on a peripheral request input. Hardware mode can also run circularly, so the block repeats without software. A software transfer with a fixed source and an incrementing destination becomes a memory fill. A fill reads the source once, writes that value across the destination, and raises a lock output so that an outside arbiter keeps other channels off the bus. A one-cycle interrupt pulse marks the completion of a chosen transfer.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the control word and the transfer index read as zero, and `bus_req`, `irq` and `lock` are low.
- R2: In software mode (control bit 5 = 0), setting the enable bit (control bit 0) starts the block at once. The channel moves LEN+1 transfers. Each transfer is one read at the source address followed by one write of the returned data at the destination address. The enable bit reads back as 0 after the last transfer.
- R3: The width field (control bits 2:1) selects 1, 2 or 4 bytes for codes 0, 1 and 2, and `bus_size` carries the code. An address whose increment bit is set (source: bit 3, destination: bit 4) steps by the width after each transfer. An address whose increment bit is clear stays fixed.
- R4: The index register (offset 5) reads the number of completed transfers and returns to zero whenever the enable bit goes from 0 to 1.
- R5: `irq` pulses for exactly one cycle after the transfer whose zero-based number equals the threshold register (offset 3) completes.
- R6: In software mode with the source fixed and the destination incrementing, the channel performs a single read and LEN+1 writes of the value read. `lock` is high on every bus cycle of that block.
- R7: In hardware mode with level sense (control bit 7 = 0), while `periph_req` is high the channel moves bursts of 1, 4 or 8 transfers for burst codes 0, 1 and 2 (control bits 9:8). While `periph_req` is low and no burst is open, no transfer is started.
- R8: In hardware mode with edge sense (control bit 7 = 1), each rising edge of `periph_req` seen while no burst is open allows exactly one burst. Holding the request high allows nothing more.
- R9: When the circular bit (control bit 6) is set in hardware mode, the index wraps to 0 after the last transfer, both addresses reload from their start registers, and the enable bit stays set. In software mode the circular bit has no effect.
- R10: When the enable bit is cleared during a transfer, the read/write pair in progress completes and no further bus request follows.
- R11: Once `bus_req` is raised, it stays high with its address and direction unchanged until `bus_gnt` is seen.
- R12: The register offsets are: 0 source start, 1 destination start, 2 LEN (transfers minus one), 3 threshold, 4 control, 5 index. Offsets 0 to 4 read back the value last written, apart from enable bits that the channel itself cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| bus_req | output | 1 | Memory-side beat request |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | AW | Byte address of the beat |
| bus_size | output | 2 | Width code of the beat |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, valid with `bus_gnt` |
| bus_gnt | input | 1 | Beat accepted this cycle |
| periph_req | input | 1 | Peripheral pacing request |
| lock | output | 1 | Fill block in progress, must not be preempted |
| irq | output | 1 | One-cycle threshold pulse |

## Verification
A wrong transfer index shows up at once as a misplaced `irq` pulse or a wrong index readback. It also shows up one transfer later as a write to the wrong destination byte, or as a circular block that wraps at the wrong address. A miscounted burst counter appears as writes that continue after a single request edge, or that stop short, within a few beats. A state machine that loses track of a beat appears in the next cycle as unequal read and write counts or as a request that changes address before it is granted. A lost fill flag appears as extra reads in the same block.

// File: rtl/dma_eng_pkg.sv
// Package: shared types and decode helpers for the single-channel transfer engine.
// Assumes a 32-bit data path; width codes above 2 are treated as 4 bytes.
package dma_eng_pkg;

    // Register offsets on the configuration port
    localparam logic [2:0] OFS_SRC  = 3'd0;
    localparam logic [2:0] OFS_DST  = 3'd1;
    localparam logic [2:0] OFS_LEN  = 3'd2;
    localparam logic [2:0] OFS_THR  = 3'd3;
    localparam logic [2:0] OFS_CTRL = 3'd4;
    localparam logic [2:0] OFS_IDX  = 3'd5;

    localparam int CTRL_W = 10;

    // Control word, MSB first
    typedef struct packed {
        logic [1:0] burst;
        logic       edge_sense;
        logic       circ;
        logic       hw_mode;
        logic       dst_inc;
        logic       src_inc;
        logic [1:0] width;
        logic       enable;
    } ctrl_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mv_state_t;

    // Bytes per transfer for a width code
    function automatic logic [3:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

    // Transfers per peripheral grant for a burst code
    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
// Module: configuration register file of the channel.
// Holds the start addresses, count, threshold and control word. Detects the
// 0->1 edge of the enable bit as a restart. A software write wins over the
// channel's own end-of-block clear in the same cycle.
module dma_regs
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic           done_clr,
    input  logic [LW:0]    idx,
    output logic [AW-1:0]  src_start,
    output logic [AW-1:0]  dst_start,
    output logic [LW-1:0]  len,
    output logic [LW-1:0]  thr,
    output ctrl_t          ctrl,
    output logic           restart
);

    // Restart when software turns the enable bit on from off
    assign restart = we && (addr == OFS_CTRL) && wdata[0] && !ctrl.enable;

    // Register storage with self-clear of enable at block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_start <= '0;
            dst_start <= '0;
            len       <= '0;
            thr       <= '0;
            ctrl      <= '0;
        end else begin
            if (done_clr) ctrl.enable <= 1'b0;
            if (we) begin
                case (addr)
                    OFS_SRC:  src_start <= wdata[AW-1:0];
                    OFS_DST:  dst_start <= wdata[AW-1:0];
                    OFS_LEN:  len       <= wdata[LW-1:0];
                    OFS_THR:  thr       <= wdata[LW-1:0];
                    OFS_CTRL: ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_SRC:  rdata = 32'(src_start);
            OFS_DST:  rdata = 32'(dst_start);
            OFS_LEN:  rdata = 32'(len);
            OFS_THR:  rdata = 32'(thr);
            OFS_CTRL: rdata = 32'(ctrl);
            OFS_IDX:  rdata = 32'(idx);
            default:  rdata = '0;
        endcase
    end

    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx == '0)); // R4

endmodule

// File: rtl/dma_pacer.sv
// Module: peripheral pacing for hardware request mode.
// Opens a burst of 1/4/8 transfers on a request level or rising edge, but only
// while no burst is open. Software mode always allows a transfer.
module dma_pacer
    import dma_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_mode,
    input  logic       edge_sense,
    input  logic [1:0] burst,
    input  logic       periph_req,
    input  logic       restart,
    input  logic       beat_done,
    output logic       beat_ok
);

    logic       req_q;
    logic [3:0] left;
    logic       trig;

    // Level or rising-edge trigger on the request input
    assign trig    = hw_mode && (edge_sense ? (periph_req && !req_q) : periph_req);
    assign beat_ok = !hw_mode || (left != '0);

    // Burst credit counter and request history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            left  <= '0;
        end else begin
            req_q <= periph_req;
            if (restart)                  left <= '0;
            else if (left == '0) begin
                if (trig)                 left <= burst_beats(burst);
            end else if (beat_done)       left <= left - 4'd1;
        end
    end

    AST_PACED_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && beat_done) |-> (left != '0)); // R7

endmodule

// File: rtl/dma_mover.sv
// Module: transfer sequencer. Each transfer is a read beat, then a write beat
// of the same data. Tracks the live addresses and the completed-transfer index,
// wraps in circular hardware mode, and re-uses one read value in fill mode.
// Assumes the bus returns read data in the cycle of the grant.
module dma_mover
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctrl_t          ctrl,
    input  logic [AW-1:0]  src_start,
    input  logic [AW-1:0]  dst_start,
    input  logic [LW-1:0]  len,
    input  logic [LW-1:0]  thr,
    input  logic           restart,
    input  logic           beat_ok,
    output logic [LW:0]    idx,
    output logic           beat_done,
    output logic           done_clr,
    output logic           irq,
    output logic           lock,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [31:0]    bus_wdata,
    input  logic [31:0]    bus_rdata,
    input  logic           bus_gnt
);

    mv_state_t     state;
    logic [AW-1:0] cur_src, cur_dst;
    logic [31:0]   data_q;
    logic          have_val;
    logic          fill, circ_eff, last;
    logic [AW-1:0] step;

    assign fill      = !ctrl.hw_mode && !ctrl.src_inc && ctrl.dst_inc;
    assign circ_eff  = ctrl.circ && ctrl.hw_mode;
    assign last      = (idx == {1'b0, len});
    assign step      = AW'(width_bytes(ctrl.width));
    assign beat_done = (state == ST_WR) && bus_gnt;
    assign done_clr  = beat_done && last && !circ_eff;
    assign lock      = fill && (ctrl.enable || state != ST_IDLE);

    assign bus_req   = (state != ST_IDLE);
    assign bus_we    = (state == ST_WR);
    assign bus_addr  = (state == ST_WR) ? cur_dst : cur_src;
    assign bus_size  = ctrl.width;
    assign bus_wdata = data_q;

    // Sequencer, address stepping and index counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            data_q   <= '0;
            have_val <= 1'b0;
            idx      <= '0;
        end else if (restart) begin
            idx      <= '0;
            cur_src  <= src_start;
            cur_dst  <= dst_start;
            have_val <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (ctrl.enable && beat_ok)
                             state <= (fill && have_val) ? ST_WR : ST_RD;
                ST_RD:   if (bus_gnt) begin
                             data_q   <= bus_rdata;
                             have_val <= 1'b1;
                             state    <= ST_WR;
                         end
                ST_WR:   if (bus_gnt) begin
                             state <= ST_IDLE;
                             if (last && circ_eff) begin
                                 idx     <= '0;
                                 cur_src <= src_start;
                                 cur_dst <= dst_start;
                             end else begin
                                 idx <= idx + 1'b1;
                                 if (ctrl.src_inc) cur_src <= cur_src + step;
                                 if (ctrl.dst_inc) cur_dst <= cur_dst + step;
                             end
                         end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Threshold pulse, one cycle after the matching transfer
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= beat_done && (idx == {1'b0, thr});
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R11
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_FILL_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && fill && !restart) |-> !have_val); // R6
    AST_DRAIN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable && state == ST_IDLE) |=> !bus_req); // R10

endmodule

// File: rtl/dma_chan_engine.sv
// Module: top of one DMA channel. Connects the register file, the pacing
// logic and the transfer sequencer. Assumes a single-cycle grant handshake
// and that software reprograms the channel only while it is idle.
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [31:0]    bus_wdata,
    input  logic [31:0]    bus_rdata,
    input  logic           bus_gnt,
    input  logic           periph_req,
    output logic           lock,
    output logic           irq
);

    ctrl_t          ctrl;
    logic [AW-1:0]  src_start, dst_start;
    logic [LW-1:0]  len, thr;
    logic [LW:0]    idx;
    logic           restart, done_clr, beat_done, beat_ok;

    dma_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .done_clr(done_clr), .idx(idx),
        .src_start(src_start), .dst_start(dst_start), .len(len), .thr(thr),
        .ctrl(ctrl), .restart(restart)
    );

    dma_pacer u_pacer (
        .clk(clk), .rst_n(rst_n), .hw_mode(ctrl.hw_mode),
        .edge_sense(ctrl.edge_sense), .burst(ctrl.burst),
        .periph_req(periph_req), .restart(restart), .beat_done(beat_done),
        .beat_ok(beat_ok)
    );

    dma_mover #(.AW(AW), .LW(LW)) u_mover (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .src_start(src_start),
        .dst_start(dst_start), .len(len), .thr(thr), .restart(restart),
        .beat_ok(beat_ok), .idx(idx), .beat_done(beat_done),
        .done_clr(done_clr), .irq(irq), .lock(lock), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_gnt(bus_gnt)
    );

endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we, lock, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_gnt = 1'b0;
    logic        periph_req = 1'b0;

    dma_chan_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_gnt(bus_gnt),
        .periph_req(periph_req), .lock(lock), .irq(irq)
    );

    always #10 clk = ~clk;

    logic [7:0] mem  [256];
    logic [7:0] snap [256];
    int n_chk = 0, n_bad = 0;
    int rd_cnt, wr_cnt, irq_cnt, irq_at, lock_miss, hold_bad = 0;
    int wr_min, wr_max;
    bit watch_lock = 0, done = 0;
    logic        p_req = 0, p_gnt = 0, p_we = 0;
    logic [31:0] p_addr = '0;

    // Memory model: random grant, data handled at the falling edge
    always @(negedge clk) begin
        if (irq) begin irq_cnt++; irq_at = wr_cnt; end
        if (p_req && !p_gnt && (!bus_req || bus_addr != p_addr || bus_we != p_we))
            hold_bad++;
        if (watch_lock && bus_req && !lock) lock_miss++;
        bus_gnt = bus_req && ($urandom % 4 != 0);
        if (bus_gnt) begin
            if (bus_we) begin
                for (int b = 0; b < (1 << bus_size) && b < 4; b++)
                    mem[(bus_addr + b) & 8'hFF] = bus_wdata[8*b +: 8];
                wr_cnt++;
                if (int'(bus_addr) < wr_min) wr_min = int'(bus_addr);
                if (int'(bus_addr) > wr_max) wr_max = int'(bus_addr);
            end else begin
                bus_rdata = '0;
                for (int b = 0; b < (1 << bus_size) && b < 4; b++)
                    bus_rdata[8*b +: 8] = mem[(bus_addr + b) & 8'hFF];
                rd_cnt++;
            end
        end
        p_req = bus_req; p_gnt = bus_gnt; p_we = bus_we; p_addr = bus_addr;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit en, input int w, input bit si,
        input bit di, input bit hw, input bit circ, input bit edg, input int burst);
        return {22'd0, 2'(burst), edg, circ, hw, di, si, 2'(w), en};
    endfunction

    task automatic clr_counts();
        rd_cnt = 0; wr_cnt = 0; irq_cnt = 0; irq_at = -1; lock_miss = 0;
        wr_min = 9999; wr_max = -1;
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
    endtask

    task automatic wait_off(input int max);
        logic [31:0] c;
        for (int i = 0; i < max; i++) begin
            @(negedge clk); rd_reg(3'd4, c);
            if (!c[0]) break;
        end
    endtask

    function automatic int cmp_bytes(input int s, input int d, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[(d + i) & 255] !== snap[(s + i) & 255]) bad++;
        return bad;
    endfunction

    task automatic setup(input int s, input int d, input int len, input int thr);
        wr_reg(3'd0, s); wr_reg(3'd1, d); wr_reg(3'd2, len); wr_reg(3'd3, thr);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd77));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_reg(3'd4, v); chk("R1 ctrl", v, 0);
        rd_reg(3'd5, v); chk("R1 idx", v, 0);
        chk("R1 outputs", {29'd0, bus_req, irq, lock}, 0);

        // R12 register readback
        wr_reg(3'd0, 32'h1234_5678); rd_reg(3'd0, v); chk("R12 src", v, 32'h1234_5678);
        wr_reg(3'd3, 32'h0000_00A5); rd_reg(3'd3, v); chk("R12 thr", v, 32'hA5);

        // R2 R3 R4 R5: random copies at each width
        for (int w = 0; w < 3; w++) begin
            int n = 2 + $urandom % 6;
            int s = ($urandom % 8) * 4;
            int d = 8'h80 + ($urandom % 8) * 4;
            clr_counts();
            setup(s, d, n - 1, n - 1);
            wr_reg(3'd4, mk_ctrl(1, w, 1, 1, 0, 0, 0, 0));
            wait_off(2000);
            chk("R2 data", cmp_bytes(s, d, n << w), 0);
            chk("R2 reads", rd_cnt, n);
            chk("R2 writes", wr_cnt, n);
            rd_reg(3'd5, v); chk("R4 idx final", v, n);
            repeat (3) @(negedge clk);
            chk("R5 irq count", irq_cnt, 1);
            chk("R5 irq at last", irq_at, n);
            chk("R2 idle after", bus_req, 0);
        end

        // R5 mid-block threshold
        clr_counts();
        setup(0, 8'h90, 5, 2);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 0, 0, 0, 0));
        wait_off(2000); repeat (3) @(negedge clk);
        chk("R5 mid count", irq_cnt, 1);
        chk("R5 mid position", irq_at, 3);

        // R6 fill: fixed source, incrementing destination
        clr_counts(); watch_lock = 1;
        setup(8'h10, 8'h40, 4, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 2, 0, 1, 0, 0, 0, 0));
        wait_off(2000); repeat (2) @(negedge clk); watch_lock = 0;
        chk("R6 single read", rd_cnt, 1);
        chk("R6 writes", wr_cnt, 5);
        chk("R6 lock held", lock_miss, 0);
        begin
            int bad = 0;
            for (int k = 0; k < 5; k++) bad += cmp_bytes(8'h10, 8'h40 + 4*k, 4);
            chk("R6 fill value", bad, 0);
        end

        // R3 fixed destination
        clr_counts();
        setup(8'h20, 8'hA0, 3, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 0, 0, 0, 0, 0));
        wait_off(2000);
        chk("R3 fixed dst last", mem[8'hA0], snap[8'h23]);
        chk("R3 fixed dst neighbour", mem[8'hA1], snap[8'hA1]);
        chk("R3 fixed dst range", wr_max, 8'hA0);

        // R7 level sense, burst of 4
        clr_counts();
        setup(8'h00, 8'hC0, 7, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 2, 1, 1, 1, 0, 0, 1));
        repeat (20) @(negedge clk);
        chk("R7 no request no move", wr_cnt, 0);
        periph_req = 1;
        wait_off(3000);
        periph_req = 0;
        chk("R7 level writes", wr_cnt, 8);
        chk("R7 level data", cmp_bytes(0, 8'hC0, 32), 0);

        // R8 edge sense, burst of 4, request held high
        clr_counts();
        setup(8'h00, 8'h80, 11, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 1, 0, 1, 1));
        @(negedge clk); periph_req = 1;
        repeat (150) @(negedge clk);
        chk("R8 one burst", wr_cnt, 4);
        periph_req = 0; @(negedge clk); periph_req = 1; @(negedge clk); periph_req = 0;
        repeat (150) @(negedge clk);
        chk("R8 second burst", wr_cnt, 8);
        rd_reg(3'd5, v); chk("R4 idx paced", v, 8);
        rd_reg(3'd4, v); chk("R8 still enabled", v[0], 1);
        wr_reg(3'd4, mk_ctrl(0, 0, 1, 1, 1, 0, 1, 1));
        repeat (10) @(negedge clk);

        // R8 burst of 8 from one edge
        clr_counts();
        setup(8'h00, 8'h80, 15, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 1, 0, 1, 2));
        @(negedge clk); periph_req = 1; @(negedge clk); periph_req = 0;
        repeat (200) @(negedge clk);
        chk("R8 burst eight", wr_cnt, 8);
        wr_reg(3'd4, mk_ctrl(0, 0, 1, 1, 1, 0, 1, 2));
        repeat (10) @(negedge clk);

        // R9 circular in hardware mode
        clr_counts();
        setup(8'h00, 8'hC0, 3, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 2, 1, 1, 1, 1, 0, 0));
        periph_req = 1;
        for (int i = 0; i < 3000 && wr_cnt < 10; i++) @(negedge clk);
        periph_req = 0;
        repeat (30) @(negedge clk);
        rd_reg(3'd4, v); chk("R9 enable kept", v[0], 1);
        rd_reg(3'd5, v); chk("R9 index wraps", v, wr_cnt % 4);
        chk("R9 lowest write", wr_min, 8'hC0);
        chk("R9 highest write", wr_max, 8'hCC);
        chk("R9 data", cmp_bytes(0, 8'hC0, 16), 0);
        wr_reg(3'd4, mk_ctrl(0, 2, 1, 1, 1, 1, 0, 0));
        repeat (10) @(negedge clk);

        // R9 circular bit ignored in software mode
        clr_counts();
        setup(8'h00, 8'h80, 2, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 0, 1, 0, 0));
        wait_off(2000);
        chk("R9 sw not circular", wr_cnt, 3);

        // R10 disable during a long block, then R4 restart
        clr_counts();
        setup(8'h00, 8'h80, 40, 16'hFFFF);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 0, 0, 0, 0));
        repeat (15) @(negedge clk);
        wr_reg(3'd4, mk_ctrl(0, 0, 1, 1, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R10 pair completes", rd_cnt, wr_cnt);
        chk("R10 stopped early", (wr_cnt < 41), 1);
        chk("R10 no request", bus_req, 0);
        rd_reg(3'd5, v); chk("R4 idx at stop", v, wr_cnt);
        wr_reg(3'd4, mk_ctrl(1, 0, 1, 1, 0, 0, 0, 0));
        rd_reg(3'd5, v); chk("R4 idx restart", v, 0);
        clr_counts();
        wait_off(3000);
        rd_reg(3'd5, v); chk("R4 idx after restart", v, 41);

        chk("R11 request held until grant", hold_bad, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule